// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt lines from peripherals and presents them to a processor as one request line plus a set of 32-bit registers on a simple word bus. The bus has an address, a write strobe, write data and combinational read data. Each line is fixed at build time as either edge-captured or level-sensitive. A captured line is held in a status bit. The status bit is gated by a per-line enable bit to form a pending bit. The lowest-numbered pending line is reported as a vector number.

Software never changes one enable bit with a read-modify-write. It writes a one-hot or multi-bit mask to a set port or a clear port, and only the named bits move. It acknowledges requests by writing a mask to the acknowledge port. A two-bit master control must have both its controller-on bit and its output-drive bit at 1 before the request line can rise.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read 0, the request output is 0, and the vector reads 0xFFFFFFFF.
- R2: For a line whose bit in EDGE_MASK is 1, a 0-to-1 change seen between two clock edges sets its status bit (offset 0x00, bit i for line i). The bit stays set until it is acknowledged.
- R3: For a line whose bit in EDGE_MASK is 0, the status bit is set on every clock edge at which the line is high. An acknowledge cannot clear it while the line stays high. The bit stays set after the line falls, until it is acknowledged.
- R4: A write to offset 0x10 sets each enable bit whose data bit is 1. A write to offset 0x14 clears each enable bit whose data bit is 1. All other enable bits keep their value. The enable register reads back at offset 0x08.
- R5: A write to offset 0x08 replaces the whole enable register with the written data. Writing 0 masks every line.
- R6: The pending register at offset 0x04 reads as status AND enable.
- R7: The master register at offset 0x1C holds bit 0 (controller on) and bit 1 (drive output). The request output is 1 only when both bits are 1 and at least one pending bit is 1.
- R8: The vector register at offset 0x18 reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending.
- R9: A write to offset 0x0C clears each status bit whose data bit is 1, and writing all ones clears them all. If a new capture happens in the same cycle as the acknowledge, the capture wins.
- R10: Reads of offsets 0x0C, 0x10 and 0x14, and of any offset from 0x20 up, return 0. Writes to offsets 0x00, 0x04 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt lines, synchronous to clk |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench goes after the bit-masking corners. A set or clear port that touched unnamed bits would change enable bits that no write asked for. An acknowledge that lost to a capture arriving in the same cycle would drop a real edge. A level line must still read as captured after an acknowledge while it is held high, so a design that treated it as sticky-edge would show the bit going low. The master gate is checked with only one of its two bits set, where a design that ORed them would raise the output early. The vector is checked both with several lines pending and with none, where a design that chose the highest index or returned 0 for the idle case would disagree.

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int          N_SRC     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_000F,
  parameter int          ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_MST  = ADDR_W'(8'h1C);
  localparam logic [N_SRC-1:0]  EDGE   = EDGE_MASK[N_SRC-1:0];

  logic [N_SRC-1:0] status_q, enable_q, prev_q, pending, capture, ack_bits, wbits;
  logic [1:0]       master_q;
  logic [31:0]      vector;

  assign wbits    = bus_wdata[N_SRC-1:0];
  assign ack_bits = (bus_we && bus_addr == A_ACK) ? wbits : '0;
  assign capture  = (EDGE & irq_in & ~prev_q) | (~EDGE & irq_in);
  assign pending  = status_q & enable_q;
  assign irq_out  = (|pending) && (master_q == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      prev_q   <= '0;
      master_q <= '0;
    end else begin
      prev_q   <= irq_in;
      status_q <= (status_q & ~ack_bits) | capture;
      if (bus_we) begin
        case (bus_addr)
          A_EN:    enable_q <= wbits;
          A_SET:   enable_q <= enable_q | wbits;
          A_CLR:   enable_q <= enable_q & ~wbits;
          A_MST:   master_q <= bus_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    vector = 32'hFFFF_FFFF;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pending[i]) vector = 32'(i);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT:  bus_rdata[N_SRC-1:0] = status_q;
      A_PEND:  bus_rdata[N_SRC-1:0] = pending;
      A_EN:    bus_rdata[N_SRC-1:0] = enable_q;
      A_VEC:   bus_rdata = vector;
      A_MST:   bus_rdata[1:0] = master_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int          N_SRC     = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_000F,
  parameter int          ADDR_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  irq_in,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic [N_SRC-1:0]  status,
  input logic [N_SRC-1:0]  enable,
  input logic [1:0]        master
);
  localparam logic [N_SRC-1:0] LVL = ~EDGE_MASK[N_SRC-1:0];
  logic [N_SRC-1:0] w;
  logic is_ack, is_set, is_clr;
  assign w      = bus_wdata[N_SRC-1:0];
  assign is_ack = bus_we && bus_addr == ADDR_W'(8'h0C);
  assign is_set = bus_we && bus_addr == ADDR_W'(8'h10);
  assign is_clr = bus_we && bus_addr == ADDR_W'(8'h14);

  // R2
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ack |=> ((($past(status)) & ~status) == '0));
  // R3
  level_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_in & LVL)) |=> (((($past(irq_in)) & LVL) & ~status) == '0));
  // R4
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_set |=> ((enable & $past(w)) == $past(w)));
  // R4
  clear_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> ((enable & $past(w)) == '0));
  // R7
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (master == 2'b11 && (|(status & enable))));
  // R8
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8'h18) && (|(status & enable))) |-> (bus_rdata < 32'(N_SRC)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .status(status_q), .enable(enable_q), .master(master_q));

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int          N  = 8;
  localparam logic [31:0] EM = 32'h0000_000F;
  localparam int          AW = 6;

  logic clk = 0, rst_n = 0, bus_we = 0, irq_out;
  logic [N-1:0] irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vec_ctrl #(.N_SRC(N), .EDGE_MASK(EM), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  bit [N-1:0] m_st, m_en, m_prev;
  bit [1:0]   m_mst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= '0; m_en <= '0; m_prev <= '0; m_mst <= '0;
    end else begin
      bit [N-1:0] ns, ne;
      int a;
      a  = int'(bus_addr);
      ns = m_st; ne = m_en;
      for (int i = 0; i < N; i++) begin
        if (bus_we && a == 12 && bus_wdata[i]) ns[i] = 0;
        if (EM[i] ? (irq_in[i] && !m_prev[i]) : irq_in[i]) ns[i] = 1;
        if (bus_we && a == 8)  ne[i] = bus_wdata[i];
        if (bus_we && a == 16 && bus_wdata[i]) ne[i] = 1;
        if (bus_we && a == 20 && bus_wdata[i]) ne[i] = 0;
      end
      if (bus_we && a == 28) m_mst <= bus_wdata[1:0];
      m_st <= ns; m_en <= ne; m_prev <= irq_in;
    end
  end

  function automatic logic [31:0] m_read(int a);
    bit [N-1:0] p;
    p = m_st & m_en;
    case (a)
      0:  return 32'(m_st);
      4:  return 32'(p);
      8:  return 32'(m_en);
      24: begin
        for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
      end
      28: return 32'(m_mst);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2"; 4: return "R6"; 8: return "R4";
      24: return "R8"; 28: return "R7"; default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R7 irq_out model", 32'(irq_out), 32'((|(m_st & m_en)) && m_mst == 2'b11));
    chk(tag_of(int'(bus_addr)), bus_rdata, m_read(int'(bus_addr)));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1; bus_addr = AW'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk); #1; bus_we = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    bus_addr = AW'(a); #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse(int i);
    @(negedge clk); #1; irq_in[i] = 1;
    @(negedge clk); #1; irq_in[i] = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    rd(0, 0, "R1 status"); rd(8, 0, "R1 enable"); rd(28, 0, "R1 master");
    rd(24, 32'hFFFF_FFFF, "R1 vector"); chk("R1 irq_out", 32'(irq_out), 0);
    // R4
    wr(16, 32'h05); rd(8, 32'h05, "R4 set");
    wr(16, 32'h02); wr(20, 32'h04); rd(8, 32'h03, "R4 set/clear");
    // R5
    wr(8, 32'hF0); rd(8, 32'hF0, "R5 direct");
    wr(8, 0); rd(8, 0, "R5 zero");
    wr(8, 32'hFF);
    // R2 / R7
    pulse(2); repeat (3) @(negedge clk); #1;
    rd(0, 32'h04, "R2 sticky");
    chk("R7 master off", 32'(irq_out), 0);
    wr(28, 1); chk("R7 only bit0", 32'(irq_out), 0);
    wr(28, 2); chk("R7 only bit1", 32'(irq_out), 0);
    wr(28, 3); chk("R7 both bits", 32'(irq_out), 1);
    rd(24, 2, "R8 vector 2");
    pulse(1); @(negedge clk); #1; rd(24, 1, "R8 lowest wins");
    // R9
    wr(12, 32'h02); rd(24, 2, "R9 ack one");
    wr(12, 32'hFFFF_FFFF); rd(0, 0, "R9 ack all");
    rd(24, 32'hFFFF_FFFF, "R8 none"); chk("R7 idle", 32'(irq_out), 0);
    // R3
    @(negedge clk); #1; irq_in[5] = 1;
    repeat (2) @(negedge clk); #1; rd(0, 32'h20, "R3 level set");
    wr(12, 32'h20); rd(0, 32'h20, "R3 ack while high");
    @(negedge clk); #1; irq_in[5] = 0;
    repeat (2) @(negedge clk); #1; rd(0, 32'h20, "R3 held after fall");
    wr(12, 32'h20); rd(0, 0, "R3 ack after fall");
    // R6
    @(negedge clk); #1; irq_in[6] = 1;
    wr(8, 0); rd(0, 32'h40, "R6 status"); rd(4, 0, "R6 masked");
    chk("R6 irq masked", 32'(irq_out), 0);
    wr(8, 32'h40); rd(4, 32'h40, "R6 pending");
    // R10
    rd(32, 0, "R10 unused"); rd(12, 0, "R10 ack reads 0"); rd(16, 0, "R10 set reads 0");
    wr(0, 32'hFF); rd(0, 32'h40, "R10 status write ignored");
    wr(24, 0); rd(24, 6, "R10 vector write ignored");
    // R9 capture beats ack
    wr(8, 32'hFF);
    @(negedge clk); #1; irq_in[0] = 1; bus_addr = AW'(12); bus_wdata = 32'h01; bus_we = 1;
    @(negedge clk); #1; bus_we = 0; irq_in[0] = 0;
    rd(0, 32'h41, "R9 capture wins");
    // mixed traffic, compared every clock against the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); #1;
      irq_in = N'($urandom);
      bus_we = ($urandom % 3) == 0;
      bus_addr = AW'(($urandom % 10) * 4);
      bus_wdata = $urandom;
    end
    @(negedge clk); #1; bus_we = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule